// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block steps through a stored control program one byte-wide microinstruction at a time. It drives the read address of an external microinstruction memory and reads back the addressed byte in the same cycle. Most byte values are single-word operation codes. The sequencer hands each of them to the datapath as a request and waits until the datapath reports completion. The remaining values open a two-word branch. The branch picks one of 32 condition inputs and either jumps to a 9-bit target or continues with the word after the branch.

The address is a 9-bit step counter with a page bit above it. Only reset sets the page bit, and nothing else changes it. Condition selector zero is wired internally to true, so a program can code an unconditional jump with it.

Top module: `useq_sequencer`

## Requirements
- R1: While rst_n is low at a rising edge, the step counter and page bit clear, so ucode_addr reads 0 and op_req is low. After release, the first fetch is from address 0.
- R2: ucode_addr always equals {page, counter}. A fetched byte with a value of 0 to 191 is an operation: op_req rises and op_code carries that byte.
- R3: op_req stays high with op_code and ucode_addr unchanged until op_done is sampled high. At that edge op_req drops and the counter advances by one. If op_done is already high when op_req rises, the request lasts exactly one cycle.
- R4: A byte with a value of 192 to 255 opens a branch. In the first word, bits 7:6 are 11, bits 5:1 hold the condition selector and bit 0 holds target bit 8. The next word holds target bits 7:0.
- R5: If the selected condition input is high when the branch resolves, the counter loads the target.
- R6: If the selected condition is low, execution continues at the branch address plus two.
- R7: Selector 0 always counts as true, whatever the value of cond_in[0].
- R8: An operation fetch takes one cycle and a branch takes three. op_req therefore rises 3*B+1 clock edges after the edge that ends the previous request (or after reset release), where B is the number of branches passed on the way.
- R9: The counter wraps from 511 to 0, and the page bit does not change. This holds both when an operation completes and when a branch word is stepped over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ucode_addr | output | 10 | Microinstruction memory read address {page, counter} |
| ucode_data | input | 8 | Byte read from ucode_addr, valid in the same cycle |
| op_req | output | 1 | Operation request to the datapath |
| op_code | output | 8 | Operation code, valid while op_req is high |
| op_done | input | 1 | Datapath completion, sampled while op_req is high |
| cond_in | input | 32 | Branch condition inputs; bit 0 is overridden to true |

## Verification
Two events can land on the same clock edge. The datapath's completion can coincide with the first cycle of a request, and the counter increment that follows a completion or a branch word can cross from address 511 to 0. The bench drives the first case by holding op_done high before op_req rises, on a random share of operations. It then requires a single-cycle request and the exact fetch-to-request spacing that follows. The second case is provoked by a directed program that places an operation at 509 and a falling-through branch at 510–511. A bench interpreter of the program predicts every address and code, and each one is judged against it.

// File: rtl/useq_pkg.sv
// Package: shared widths, encodings and state type for the sequencer.
// Assumes: an 8-bit microinstruction word, a 9-bit counter and 32 conditions.
package useq_pkg;
    localparam int unsigned WORD_W     = 8;
    localparam int unsigned CNT_W      = 9;
    localparam int unsigned COND_N     = 32;
    localparam int unsigned SEL_W      = $clog2(COND_N);
    localparam int unsigned OP_LIMIT   = 192;   // codes below this are operations
    localparam int unsigned ADDR_W     = CNT_W + 1;

    typedef enum logic [1:0] {
        ST_FETCH   = 2'd0,   // read and decode the word at the counter
        ST_OPWAIT  = 2'd1,   // operation issued, waiting for completion
        ST_WORD2   = 2'd2,   // read the low target byte of a branch
        ST_RESOLVE = 2'd3    // test the condition and redirect
    } seq_state_t;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_INC  = 2'd1,
        CNT_LOAD = 2'd2
    } cnt_op_t;
endpackage

// File: rtl/useq_decode.sv
// Module: classifies a fetched byte as an operation or a branch head and
// splits out the branch fields. Assumes the branch head layout
// {2'b11, selector, target bit 8}; purely combinational.
module useq_decode
    import useq_pkg::*;
#(
    parameter int unsigned W      = WORD_W,
    parameter int unsigned SW     = SEL_W,
    parameter int unsigned LIMIT  = OP_LIMIT
) (
    input  logic [W-1:0]  word_in,
    output logic          is_op,
    output logic [SW-1:0] sel_out,
    output logic          tgt_msb
);
    // Field extraction for operation/branch classification.
    always_comb begin
        is_op   = (int'(word_in) < int'(LIMIT));
        sel_out = word_in[SW:1];
        tgt_msb = word_in[0];
    end
endmodule

// File: rtl/useq_cond_sel.sv
// Module: picks one condition input by selector. Entry 0 is forced true so
// that it can serve as an unconditional jump. Assumes N is a power of two.
module useq_cond_sel #(
    parameter int unsigned N  = 32,
    parameter int unsigned SW = $clog2(N)
) (
    input  logic [N-1:0]  cond_vec,
    input  logic [SW-1:0] sel,
    output logic          hit
);
    logic [N-1:0] eff;

    // Build the effective vector: slot 0 tied high, the rest pass through.
    generate
        for (genvar i = 0; i < N; i++) begin : g_slot
            if (i == 0) begin : g_true
                assign eff[i] = cond_vec[i] | 1'b1;
            end else begin : g_pass
                assign eff[i] = cond_vec[i];
            end
        end
    endgenerate

    // Selected condition.
    always_comb hit = eff[sel];
endmodule

// File: rtl/useq_counter.sv
// Module: step counter and page bit. Holds, increments with wrap inside the
// page, or loads a target. Only reset changes the page bit.
module useq_counter
    import useq_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cnt_op_t       op,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          page
);
    // Counter update: synchronous clear, then hold/increment/load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (op)
                CNT_INC:  cnt <= cnt + 1'b1;
                CNT_LOAD: cnt <= load_val;
                default:  cnt <= cnt;
            endcase
        end
    end

    // Page bit: cleared by reset, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) page <= 1'b0;
        else        page <= page;
    end

    AST_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (page == $past(page))) else $error("page bit changed"); // R9

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CNT_INC && cnt == {CW{1'b1}}) |=> (cnt == '0)) else $error("no wrap"); // R9
endmodule

// File: rtl/useq_sequencer.sv
// Module: top of the microprogrammed sequencer. It fetches a byte each fetch
// cycle, issues operations with a request/done handshake, and runs branches
// over three cycles. Assumes memory read data is valid in the same cycle
// as the address.
module useq_sequencer
    import useq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    output logic [ADDR_W-1:0]   ucode_addr,
    input  logic [WORD_W-1:0]   ucode_data,
    output logic                op_req,
    output logic [WORD_W-1:0]   op_code,
    input  logic                op_done,
    input  logic [COND_N-1:0]   cond_in
);
    seq_state_t         state_q;
    cnt_op_t            cnt_op;
    logic [CNT_W-1:0]   cnt_q;
    logic               page_q;
    logic [WORD_W-1:0]  code_q;
    logic [SEL_W-1:0]   sel_q;
    logic [CNT_W-1:0]   tgt_q;
    logic               dec_is_op;
    logic [SEL_W-1:0]   dec_sel;
    logic               dec_tgt_msb;
    logic               cond_hit;

    useq_decode #(.W(WORD_W), .SW(SEL_W), .LIMIT(OP_LIMIT)) u_decode (
        .word_in (ucode_data),
        .is_op   (dec_is_op),
        .sel_out (dec_sel),
        .tgt_msb (dec_tgt_msb)
    );

    useq_cond_sel #(.N(COND_N), .SW(SEL_W)) u_cond (
        .cond_vec (cond_in),
        .sel      (sel_q),
        .hit      (cond_hit)
    );

    useq_counter #(.CW(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (cnt_op),
        .load_val (tgt_q),
        .cnt      (cnt_q),
        .page     (page_q)
    );

    // Counter command for the current state.
    always_comb begin
        cnt_op = CNT_HOLD;
        unique case (state_q)
            ST_FETCH:   cnt_op = dec_is_op ? CNT_HOLD : CNT_INC;
            ST_OPWAIT:  cnt_op = op_done ? CNT_INC : CNT_HOLD;
            ST_WORD2:   cnt_op = CNT_INC;
            ST_RESOLVE: cnt_op = cond_hit ? CNT_LOAD : CNT_HOLD;
            default:    cnt_op = CNT_HOLD;
        endcase
    end

    // Sequencing state and latched instruction fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            code_q  <= '0;
            sel_q   <= '0;
            tgt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_FETCH: begin
                    if (dec_is_op) begin
                        code_q  <= ucode_data;
                        state_q <= ST_OPWAIT;
                    end else begin
                        sel_q           <= dec_sel;
                        tgt_q[CNT_W-1]  <= dec_tgt_msb;
                        state_q         <= ST_WORD2;
                    end
                end
                ST_OPWAIT: if (op_done) state_q <= ST_FETCH;
                ST_WORD2: begin
                    tgt_q[CNT_W-2:0] <= ucode_data;
                    state_q          <= ST_RESOLVE;
                end
                ST_RESOLVE: state_q <= ST_FETCH;
                default:    state_q <= ST_FETCH;
            endcase
        end
    end

    // Port outputs.
    always_comb begin
        ucode_addr = {page_q, cnt_q};
        op_req     = (state_q == ST_OPWAIT);
        op_code    = code_q;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (ucode_addr == '0 && !op_req)) else $error("reset state"); // R1

    AST_REQ_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        op_req |-> (int'(op_code) < int'(OP_LIMIT))) else $error("bad op code"); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !op_done) |=> (op_req && $stable(op_code) && $stable(ucode_addr)))
        else $error("request dropped early"); // R3

    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && op_done) |=> (!op_req && cnt_q == $past(cnt_q) + 9'd1))
        else $error("bad release"); // R3

    AST_BRANCH_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESOLVE) |=>
            (cnt_q == ($past(cond_hit) ? $past(tgt_q) : $past(cnt_q))))
        else $error("bad branch destination"); // R5

    AST_SEL0_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESOLVE && sel_q == '0) |-> cond_hit)
        else $error("selector 0 not true"); // R7
endmodule

// File: tb/useq_sequencer_bench.sv
module useq_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  ucode_addr;
    logic [7:0]  ucode_data;
    logic        op_req;
    logic [7:0]  op_code;
    logic        op_done = 1'b0;
    logic [31:0] cond_in = '0;

    logic [7:0]  mem [0:511];
    int          checks = 0;
    int          fails = 0;
    int          cycles = 0;
    int          pre_pct = 30;

    always #10 clk = ~clk;   // 50 MHz

    assign ucode_data = mem[ucode_addr[8:0]];

    useq_sequencer u_useq_sequencer (
        .clk(clk), .rst_n(rst_n), .ucode_addr(ucode_addr), .ucode_data(ucode_data),
        .op_req(op_req), .op_code(op_code), .op_done(op_done), .cond_in(cond_in)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference: walk from a start address over branches to the next operation.
    function automatic void find_op(input int start, output bit found,
                                    output int addr, output int nbr);
        int p = start;
        found = 1'b0; addr = 0; nbr = 0;
        for (int s = 0; s < 1200; s++) begin
            int w = mem[p];
            if (w < 192) begin
                found = 1'b1; addr = p; return;
            end else begin
                int sel = (w >> 1) & 31;
                int tgt = ((w & 1) << 8) | mem[(p + 1) % 512];
                bit taken = (sel == 0) || cond_in[sel];
                nbr++;
                p = taken ? tgt : (p + 2) % 512;
            end
        end
    endfunction

    function automatic logic [7:0] br_head(input int sel, input int tgt);
        return {2'b11, 5'(sel), 1'(tgt >> 8)};
    endfunction

    task automatic fill_default();
        for (int i = 0; i < 512; i++) mem[i] = 8'(i % 192);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; op_done = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(!op_req && ucode_addr == 0, "R1 reset", {op_req, ucode_addr}, 0);
        rst_n = 1'b1;
    endtask

    // Run n operations from reset, checking spacing, code, address, handshake.
    task automatic run_prog(input int n, input string tag);
        int pc = 0;
        do_reset();
        for (int k = 0; k < n; k++) begin
            bit found; int addr; int nbr; int cnt; bit pre;
            find_op(pc, found, addr, nbr);
            if (!found) return;
            pre = ($urandom % 100) < pre_pct;
            op_done = pre;
            cnt = 0;
            while (!op_req && cnt < 5000) begin
                @(posedge clk); cnt++; @(negedge clk);
            end
            chk(cnt == 3 * nbr + 1, "R8 spacing", cnt, 3 * nbr + 1);
            chk(op_code == mem[addr] && ucode_addr == 10'(addr),
                {"R2 ", tag, " code"}, op_code, mem[addr]);
            chk(ucode_addr == 10'(addr), {"R2 ", tag, " addr"}, ucode_addr, addr);
            if (!pre) begin
                int h = $urandom % 4;
                for (int j = 0; j < h; j++) begin
                    @(posedge clk); @(negedge clk);
                    chk(op_req && op_code == mem[addr] && ucode_addr == 10'(addr),
                        "R3 hold", {op_req, op_code}, {1'b1, mem[addr]});
                end
                op_done = 1'b1;
            end
            @(posedge clk); @(negedge clk);
            op_done = pre;
            chk(!op_req, pre ? "R3 one-cycle" : "R3 release", op_req, 0);
            pc = (addr + 1) % 512;
            chk(ucode_addr == 10'(pc), "R9 advance", ucode_addr, pc);
        end
        op_done = 1'b0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        // Directed: selector 0 jumps with cond_in[0] low; top operation code.
        fill_default();
        cond_in = '0;
        mem[0] = 8'd5; mem[1] = br_head(0, 9'h100); mem[2] = 8'h00;
        mem[9'h100] = 8'o277;
        run_prog(3, "R4 R7");
        // Directed: condition low falls through; then high takes the branch.
        fill_default();
        mem[0] = br_head(5, 9'h080); mem[1] = 8'h80; mem[2] = 8'h22; mem[9'h080] = 8'h33;
        cond_in = 32'h0;
        run_prog(2, "R6");
        cond_in = 32'h20;
        run_prog(2, "R5");
        // Directed: wrap across 511 after a falling-through branch at 510.
        fill_default();
        cond_in = '0;
        mem[0] = 8'h11; mem[1] = br_head(0, 509); mem[2] = 8'hFD;
        mem[509] = 8'h44; mem[510] = br_head(3, 0); mem[511] = 8'h07;
        run_prog(4, "R9");
        // Done already high when the request rises, every time.
        pre_pct = 100;
        run_prog(4, "R9");
        // Random programs.
        pre_pct = 30;
        for (int p = 0; p < 20; p++) begin
            for (int i = 0; i < 512; i++)
                mem[i] = (($urandom % 100) < 60) ? 8'($urandom % 192) : 8'(192 + $urandom % 64);
            cond_in = $urandom;
            run_prog(30, "rand");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule